// File: doc/BRIEF.md
# Early Core Invalidation LRU Replacement Controller

This block keeps the replacement state of an inclusive shared last-level cache with 16 ways per set. For every set it holds a strict recency order of the ways, from most recent (rank 0) to least recent (rank 15). On a miss it names the least recent way as the fill victim. In the same step it picks the way one rank above that victim and asks the private core caches to drop their copy of that line. The line stays valid in the shared cache and is flagged as early-invalidated.

A core that still uses the line asks for it again. It then hits in the shared cache, and that hit lifts the line to the most recent rank, so the line survives. A line that nobody asks for again slides to the least recent rank and goes out on the next miss in its set. The controller reports on each hit whether the line had been pre-invalidated, and on each miss whether the victim was such an unclaimed line.

The surrounding cache does the tag lookup and supplies the set, the way that hit, and the hit/miss result. The controller returns the victim way at once. It issues the core-invalidate request one cycle later on a valid/ready port.

Top module: `ecl_lru_ctrl`

## Requirements
- R1: After reset, every set orders its ways so that way w has rank w. The victim way reported for any set is 15, no invalidate is pending, and the access port is ready.
- R2: For a miss, `victim_way` is the way that holds rank 15 (least recent) in the addressed set. The output is combinational from `acc_set`.
- R3: An accepted miss gives the victim rank 0. Every other way in that set moves one rank toward least recent.
- R4: In the cycle after an accepted miss, `inv_valid` is 1. `inv_set` carries the missed set and `inv_way` the way that held rank 14 before the fill.
- R5: The pre-invalidated way stays usable. A hit to it is accepted, and in that access cycle `hit_early` is 1.
- R6: An accepted hit gives the hit way rank 0. Ways that were more recent than it move one rank toward least recent, and ways that were less recent keep their rank.
- R7: A hit clears the early-invalidated flag of its way, so a later hit to the same line reports `hit_early` = 0.
- R8: A pre-invalidated line that is not hit reaches rank 15. The next miss in its set evicts it with `victim_early` = 1. The refilled way carries no flag, so a hit to it reports `hit_early` = 0.
- R9: While an invalidate is pending (`inv_valid` = 1 and not yet taken), `inv_set` and `inv_way` stay stable and a miss sees `acc_ready` = 0. A hit is still accepted. A request leaves when `inv_valid` and `inv_ready` are both 1 at a clock edge.
- R10: Each set keeps its own recency order and flags. An access to one set leaves all other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access accepted this cycle when high with acc_valid |
| acc_hit | input | 1 | 1 = hit in the shared cache, 0 = miss |
| acc_set | input | 3 | Set index of the access |
| acc_way | input | 4 | Way that hit (ignored on a miss) |
| victim_way | output | 4 | Least recent way of acc_set, the fill target on a miss |
| victim_early | output | 1 | Miss whose victim was pre-invalidated and never re-requested |
| hit_early | output | 1 | Hit to a line that had been pre-invalidated |
| inv_valid | output | 1 | Core-invalidate request pending |
| inv_ready | input | 1 | Core side takes the invalidate request |
| inv_set | output | 3 | Set of the line to invalidate in the core caches |
| inv_way | output | 4 | Way of the line to invalidate in the core caches |

## Verification
The bench keeps its own per-set recency list and flag table. It sweeps a long pseudo-random mix of hits and misses over all eight sets, with hits biased toward the flagged least-recent line. This catches an order that shifts the wrong ways on a hit; such a design picks wrong victims many accesses later. Directed cases target the first miss after reset, where an off-by-one candidate would name way 15 twice. They also cover a hit to the flagged line while its invalidate is still stalled, where a design that blocks hits would deadlock on the stall and one that loses the flag would report no early hit. Two misses in a row with no hit are checked as well, where a design that never sets or never clears the flag shows a wrong `victim_early`.

// File: rtl/ecl_pkg.sv
package ecl_pkg;

   // Fixed associativity of the shared cache.
   localparam int unsigned ECL_WAYS_DEFAULT = 16;

   // Kind of access presented by the tag pipeline.
   typedef enum logic {
      ACC_MISS = 1'b0,
      ACC_HIT  = 1'b1
   } acc_kind_e;

   // Onehot of a way index, width-generic through a fixed upper bound.
   function automatic logic [63:0] way_bit(input int unsigned idx);
      logic [63:0] v;
      v = '0;
      v[idx[5:0]] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/ecl_rank_find.sv
module ecl_rank_find #(
   parameter int unsigned WAYS = 16,
   localparam int unsigned RW  = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][RW-1:0] ranks,
   input  logic [RW-1:0]           target,
   output logic [RW-1:0]           way,
   output logic                    found
);

   always_comb begin
      way   = '0;
      found = 1'b0;
      for (int w = 0; w < int'(WAYS); w++) begin
         if (ranks[w] == target) begin
            way   = RW'(w);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ecl_rank_next.sv
module ecl_rank_next #(
   parameter int unsigned WAYS = 16,
   localparam int unsigned RW  = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][RW-1:0] ranks_in,
   input  logic [RW-1:0]           sel_way,
   output logic [WAYS-1:0][RW-1:0] ranks_out,
   output logic [WAYS-1:0]         mru_vec
);

   logic [RW-1:0] sel_rank;

   assign sel_rank = ranks_in[sel_way];

   // One compare-and-increment slice per way.
   for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
      always_comb begin
         if (RW'(w) == sel_way) begin
            ranks_out[w] = '0;
         end else if (ranks_in[w] < sel_rank) begin
            ranks_out[w] = ranks_in[w] + RW'(1);
         end else begin
            ranks_out[w] = ranks_in[w];
         end
      end
      assign mru_vec[w] = (ranks_out[w] == '0);
   end

endmodule

// File: rtl/ecl_inv_port.sv
module ecl_inv_port #(
   parameter int unsigned SW = 3,
   parameter int unsigned WW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [SW-1:0] load_set,
   input  logic [WW-1:0] load_way,
   input  logic          inv_ready,
   output logic          inv_valid,
   output logic [SW-1:0] inv_set,
   output logic [WW-1:0] inv_way
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inv_valid <= 1'b0;
         inv_set   <= '0;
         inv_way   <= '0;
      end else if (load) begin
         inv_valid <= 1'b1;
         inv_set   <= load_set;
         inv_way   <= load_way;
      end else if (inv_valid && inv_ready) begin
         inv_valid <= 1'b0;
      end
   end

   // R9: a stalled request keeps its payload until taken.
   a_r9_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_set) && $stable(inv_way)));

   // R9: no new request may overwrite a pending one.
   a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !inv_ready) |-> !load);

endmodule

// File: rtl/ecl_lru_ctrl.sv
module ecl_lru_ctrl #(
   parameter int unsigned NUM_WAYS   = ecl_pkg::ECL_WAYS_DEFAULT,
   parameter int unsigned NUM_SETS   = 8,
   parameter bit          STALL_HITS = 1'b0,
   localparam int unsigned WW        = $clog2(NUM_WAYS),
   localparam int unsigned SW        = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   output logic          acc_ready,
   input  logic          acc_hit,
   input  logic [SW-1:0] acc_set,
   input  logic [WW-1:0] acc_way,
   output logic [WW-1:0] victim_way,
   output logic          victim_early,
   output logic          hit_early,
   output logic          inv_valid,
   input  logic          inv_ready,
   output logic [SW-1:0] inv_set,
   output logic [WW-1:0] inv_way
);

   localparam logic [WW-1:0] RANK_LRU  = WW'(NUM_WAYS - 1);
   localparam logic [WW-1:0] RANK_CAND = WW'(NUM_WAYS - 2);

   // Elaboration-time parameter checks.
   if (NUM_WAYS < 3) begin : g_chk_ways_min
      $error("ecl_lru_ctrl: NUM_WAYS must be at least 3");
   end
   if ((1 << WW) != NUM_WAYS) begin : g_chk_ways_pow2
      $error("ecl_lru_ctrl: NUM_WAYS must be a power of two");
   end
   if (NUM_WAYS > 64) begin : g_chk_ways_max
      $error("ecl_lru_ctrl: NUM_WAYS above 64 not supported");
   end
   if (NUM_SETS < 1) begin : g_chk_sets
      $error("ecl_lru_ctrl: NUM_SETS must be at least 1");
   end

   // Per-set state.
   logic [NUM_WAYS-1:0][WW-1:0] rank_q [NUM_SETS];
   logic [NUM_WAYS-1:0]         eci_q  [NUM_SETS];

   logic [NUM_WAYS-1:0][WW-1:0] cur_ranks;
   logic [NUM_WAYS-1:0]         cur_flags;
   logic [NUM_WAYS-1:0][WW-1:0] nxt_ranks;
   logic [NUM_WAYS-1:0]         nxt_flags;
   logic [NUM_WAYS-1:0]         mru_vec;
   logic [WW-1:0]               cand_way;
   logic [WW-1:0]               sel_way;
   logic                        victim_found;
   logic                        cand_found;
   logic                        acc_fire;
   logic                        miss_fire;
   logic [NUM_WAYS-1:0]         victim_oh;
   logic [NUM_WAYS-1:0]         cand_oh;
   logic [NUM_WAYS-1:0]         hit_oh;

   assign cur_ranks = rank_q[acc_set];
   assign cur_flags = eci_q[acc_set];

   // Locate least recent way and its neighbour one rank above.
   ecl_rank_find #(.WAYS(NUM_WAYS)) u_find_victim (
      .ranks  (cur_ranks),
      .target (RANK_LRU),
      .way    (victim_way),
      .found  (victim_found)
   );

   ecl_rank_find #(.WAYS(NUM_WAYS)) u_find_cand (
      .ranks  (cur_ranks),
      .target (RANK_CAND),
      .way    (cand_way),
      .found  (cand_found)
   );

   // Hit promotes the hit way, miss promotes the filled victim.
   assign sel_way = acc_hit ? acc_way : victim_way;

   ecl_rank_next #(.WAYS(NUM_WAYS)) u_next (
      .ranks_in  (cur_ranks),
      .sel_way   (sel_way),
      .ranks_out (nxt_ranks),
      .mru_vec   (mru_vec)
   );

   assign victim_oh = NUM_WAYS'(ecl_pkg::way_bit(int'(victim_way)));
   assign cand_oh   = NUM_WAYS'(ecl_pkg::way_bit(int'(cand_way)));
   assign hit_oh    = NUM_WAYS'(ecl_pkg::way_bit(int'(acc_way)));

   always_comb begin
      if (acc_hit) begin
         nxt_flags = cur_flags & ~hit_oh;
      end else begin
         nxt_flags = (cur_flags & ~victim_oh) | cand_oh;
      end
   end

   assign hit_early    = acc_valid && acc_hit && cur_flags[acc_way];
   assign victim_early = acc_valid && !acc_hit && cur_flags[victim_way];

   // Access acceptance: misses wait for the invalidate port,
   // hits optionally wait too.
   if (STALL_HITS) begin : g_stall_all
      assign acc_ready = !inv_valid;
   end else begin : g_stall_miss
      assign acc_ready = acc_hit || !inv_valid;
   end

   assign acc_fire  = acc_valid && acc_ready;
   assign miss_fire = acc_fire && (acc_hit == ecl_pkg::ACC_MISS);

   // State registers, one slice per set.
   for (genvar s = 0; s < int'(NUM_SETS); s++) begin : g_set
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int w = 0; w < int'(NUM_WAYS); w++) begin
               rank_q[s][w] <= WW'(w);
            end
            eci_q[s] <= '0;
         end else if (acc_fire && (acc_set == SW'(s))) begin
            rank_q[s] <= nxt_ranks;
            eci_q[s]  <= nxt_flags;
         end
      end
   end

   ecl_inv_port #(.SW(SW), .WW(WW)) u_inv (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (miss_fire),
      .load_set  (acc_set),
      .load_way  (cand_way),
      .inv_ready (inv_ready),
      .inv_valid (inv_valid),
      .inv_set   (inv_set),
      .inv_way   (inv_way)
   );

   // R2: every set always owns exactly one least recent way and one neighbour.
   a_r2_victim_found: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (victim_found && cand_found && (victim_way != cand_way)));

   // R3 / R6: after any update exactly one way sits at rank 0.
   a_r3_single_mru: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> ($countones(mru_vec) == 1));

   // R4: a miss produces an invalidate for the pre-fill neighbour way.
   a_r4_inv_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
      miss_fire |=> (inv_valid && (inv_set == $past(acc_set)) && (inv_way == $past(cand_way))));

   // R8: a flagged line can only sit at the least recent rank.
   a_r8_flag_only_lru: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> ((cur_flags & ~victim_oh) == '0));

   // R9: misses never pass a pending invalidate.
   a_r9_miss_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !miss_fire);

endmodule

// File: tb/ecl_lru_ctrl_tb.sv
module ecl_lru_ctrl_tb;

   localparam int WAYS = 16;
   localparam int SETS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic       acc_ready;
   logic       acc_hit = 1'b0;
   logic [2:0] acc_set = '0;
   logic [3:0] acc_way = '0;
   logic [3:0] victim_way;
   logic       victim_early;
   logic       hit_early;
   logic       inv_valid;
   logic       inv_ready = 1'b0;
   logic [2:0] inv_set;
   logic [3:0] inv_way;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   int ord [SETS][WAYS];
   bit flg [SETS][WAYS];

   always #4 clk = ~clk;

   ecl_lru_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_valid    (acc_valid),
      .acc_ready    (acc_ready),
      .acc_hit      (acc_hit),
      .acc_set      (acc_set),
      .acc_way      (acc_way),
      .victim_way   (victim_way),
      .victim_early (victim_early),
      .hit_early    (hit_early),
      .inv_valid    (inv_valid),
      .inv_ready    (inv_ready),
      .inv_set      (inv_set),
      .inv_way      (inv_way)
   );

   task automatic chk(input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic model_promote(input int s, input int w);
      int p;
      p = 0;
      for (int i = 0; i < WAYS; i++) if (ord[s][i] == w) p = i;
      for (int i = p; i > 0; i--) ord[s][i] = ord[s][i-1];
      ord[s][0] = w;
   endtask

   // Caller is at a falling edge.
   task automatic do_hit(input int s, input int w, input string tag);
      acc_valid = 1'b1; acc_hit = 1'b1; acc_set = 3'(s); acc_way = 4'(w);
      #1;
      chk(int'(acc_ready), 1, {tag, " hit ready"});
      chk(int'(hit_early), int'(flg[s][w]), {tag, " hit_early"});
      @(posedge clk);
      flg[s][w] = 0;
      model_promote(s, w);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic do_miss(input int s, input string tag);
      int v;
      int c;
      v = ord[s][WAYS-1];
      c = ord[s][WAYS-2];
      acc_valid = 1'b1; acc_hit = 1'b0; acc_set = 3'(s);
      #1;
      chk(int'(acc_ready), 1, {tag, " miss ready"});
      chk(int'(victim_way), v, {tag, " R2 victim_way"});
      chk(int'(victim_early), int'(flg[s][v]), {tag, " R8 victim_early"});
      @(posedge clk);
      flg[s][v] = 0;
      flg[s][c] = 1;
      model_promote(s, v);
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
      chk(int'(inv_valid), 1, {tag, " R4 inv_valid"});
      chk(int'(inv_set), s, {tag, " R4 inv_set"});
      chk(int'(inv_way), c, {tag, " R4 inv_way"});
      inv_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      inv_ready = 1'b0;
      #1;
      chk(int'(inv_valid), 0, {tag, " R9 inv taken"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            ord[s][w] = w;
            flg[s][w] = 0;
         end

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1: reset state of every set.
      chk(int'(acc_ready), 1, "R1 ready after reset");
      chk(int'(inv_valid), 0, "R1 no invalidate after reset");
      for (int s = 0; s < SETS; s++) begin
         acc_set = 3'(s);
         #1;
         chk(int'(victim_way), 15, "R1 reset victim");
      end
      @(negedge clk);

      // R2 R3 R4: first miss in set 3.
      acc_valid = 1'b1; acc_hit = 1'b0; acc_set = 3'd3;
      #1;
      chk(int'(victim_way), 15, "R2 first victim");
      @(posedge clk);
      flg[3][15] = 0; flg[3][14] = 1; model_promote(3, 15);
      @(negedge clk);
      acc_valid = 1'b0;
      #1;
      chk(int'(inv_valid), 1, "R4 inv after first miss");
      chk(int'(inv_way), 14, "R4 inv way 14");
      chk(int'(inv_set), 3, "R4 inv set 3");

      // R9: request held while not taken, miss stalled, hit passes.
      @(negedge clk);
      acc_valid = 1'b1; acc_hit = 1'b0; acc_set = 3'd1;
      #1;
      chk(int'(acc_ready), 0, "R9 miss stalled");
      chk(int'(inv_valid), 1, "R9 inv held");
      chk(int'(inv_way), 14, "R9 inv way stable");
      acc_hit = 1'b1; acc_set = 3'd3; acc_way = 4'd14;
      #1;
      chk(int'(acc_ready), 1, "R9 hit accepted while pending");
      chk(int'(hit_early), 1, "R5 early hit on flagged line");
      @(posedge clk);
      flg[3][14] = 0; model_promote(3, 14);
      @(negedge clk);
      acc_valid = 1'b0;
      inv_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      inv_ready = 1'b0;
      #1;
      chk(int'(inv_valid), 0, "R9 inv released");

      // R7: promoted line is no longer flagged. R6: victim after promotion.
      do_hit(3, 14, "R7");
      acc_set = 3'd3;
      #1;
      chk(int'(victim_way), 13, "R6 R3 victim after fill and promotion");

      // R8: unclaimed flagged line evicted on the next miss of its set.
      do_miss(5, "R8 first");
      acc_valid = 1'b1; acc_hit = 1'b0; acc_set = 3'd5;
      #1;
      chk(int'(victim_way), 14, "R8 drifted victim");
      chk(int'(victim_early), 1, "R8 unclaimed eviction flagged");
      acc_valid = 1'b0;
      do_miss(5, "R8 second");
      do_hit(5, 14, "R8 refilled way unflagged");

      // R10: untouched set still in reset order.
      acc_set = 3'd6;
      #1;
      chk(int'(victim_way), 15, "R10 other set unchanged");
      @(negedge clk);

      // Sweep: R2 R3 R5 R6 R7 R8 R10 against the model.
      lfsr = 16'hACE1;
      for (int n = 0; n < 2500; n++) begin
         int s;
         int w;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         s = int'(lfsr[2:0]);
         if (lfsr[5:4] == 2'b00) begin
            do_miss(s, "R10 sweep");
         end else begin
            if (lfsr[6]) w = ord[s][WAYS-1];
            else         w = ord[s][int'(lfsr[11:8])];
            do_hit(s, w, "R6 sweep");
         end
         acc_set = 3'(s);
         #1;
         chk(int'(victim_way), ord[s][WAYS-1], "R3 R6 sweep order");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule